// File: doc/BRIEF.md
# Process ID address remapper

This block sits between the address generators of a processor core and the translation stage. It holds a small process-ID register and, for eligible addresses issued by user-mode code, places that ID into the most significant address field. Two processes can therefore run from the same low virtual addresses and still reach distinct modified addresses. The decision is purely combinational, so the modified address appears in the same cycle as the request and no pipeline stage is added.

Each request carries a privilege flag and an access kind. Only ordinary user-mode fetches and data accesses are candidates for substitution. Branch-target lookups always use the raw virtual address. Breakpoint compare values and virtual addresses taken from translation descriptors are already in modified form and pass through unchanged. Because the branch-target path does not see the ID, every write of the ID register raises a one-cycle invalidate toward the branch-target buffer. This stops one virtual address from being mapped for two processes.

Top module: `pid_remap`

## Requirements
- R1: For a user-mode request (`req_user`=1) of kind 2'b00 (ordinary fetch or data) whose bits [31:25] are all zero, `out_addr` equals {PID, `req_addr`[24:0]} in the same cycle.
- R2: A privileged request (`req_user`=0) of any kind passes through unchanged: `out_addr` equals `req_addr`.
- R3: A branch-target lookup (kind 2'b01) passes through unchanged in either mode.
- R4: A breakpoint compare value (kind 2'b10) and a translation-descriptor address (kind 2'b11) pass through unchanged in either mode.
- R5: A user-mode request of kind 2'b00 with any nonzero bit in [31:25] passes through unchanged.
- R6: When `pid_wr_en` is high at a rising edge, the PID takes `pid_wr_data`[31:25], and lower write bits are ignored. `pid_rd_data` returns {PID, 25 zero bits}. Without a write, the PID holds its value.
- R7: `btb_inval` is high for the one cycle after each accepted PID write, and low in every other cycle.
- R8: During and after reset the PID is zero and `btb_inval` is low, so remapping has no effect.
- R9: `out_remapped` is high exactly when the substitution of R1 is applied, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pid_wr_en | input | 1 | Write strobe for the PID register |
| pid_wr_data | input | 32 | Write data; bits [31:25] carry the new ID |
| pid_rd_data | output | 32 | Readback: ID in [31:25], zeros below |
| req_addr | input | 32 | Virtual address from the core |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_kind | input | 2 | 00 fetch/data, 01 branch-target lookup, 10 breakpoint compare, 11 translation descriptor |
| out_addr | output | 32 | Modified virtual address |
| out_remapped | output | 1 | High when the ID was substituted |
| btb_inval | output | 1 | One-cycle branch-target buffer invalidate |

## Verification
A stale or corrupted PID shows up in the next cycle on `pid_rd_data`. It also shows up on the first eligible user-mode request with a zero top field, because that address then carries the wrong upper bits. A wrong path selection appears in the same cycle as the request: a bypass kind gains an ID or an eligible address loses it. The two cases are told apart by the value of `out_remapped` and by the address. An invalidate that is missed, late or stuck high is visible one cycle after the write that should have caused it.

// File: rtl/pid_remap_pkg.sv
package pid_remap_pkg;

    // Access kind carried with each address request
    typedef enum logic [1:0] {
        KIND_NORMAL = 2'b00,   // ordinary fetch or data access
        KIND_BTB    = 2'b01,   // branch-target lookup
        KIND_BKPT   = 2'b10,   // breakpoint compare value
        KIND_DESC   = 2'b11    // address from a translation descriptor
    } acc_kind_e;

endpackage

// File: rtl/pid_reg.sv
module pid_reg #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int LOW_W = ADDR_W - PID_W;

    typedef struct packed {
        logic [PID_W-1:0] pid;
    } state_t;

    state_t st_d, st_q;

    // lower write bits carry no state
    logic unused_low;
    assign unused_low = ^wr_data[LOW_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.pid = wr_data[ADDR_W-1 -: PID_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pid     = st_q.pid;
    assign rd_data = {st_q.pid, {LOW_W{1'b0}}};
endmodule

// File: rtl/pid_inval_gen.sv
module pid_inval_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    output logic inval
);
    typedef struct packed {
        logic inval;
    } state_t;

    state_t st_d, st_q;

    // one pulse per accepted write, in the following cycle
    always_comb begin
        st_d       = st_q;
        st_d.inval = wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inval = st_q.inval;
endmodule

// File: rtl/pid_addr_xlate.sv
module pid_addr_xlate
    import pid_remap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              user_mode,
    input  acc_kind_e         kind,
    input  logic [PID_W-1:0]  pid,
    output logic [ADDR_W-1:0] addr_out,
    output logic              remapped
);
    localparam int LOW_W = ADDR_W - PID_W;

    logic top_zero;
    logic eligible;

    always_comb begin
        top_zero = (addr_in[ADDR_W-1 -: PID_W] == '0);
        eligible = 1'b0;
        unique case (kind)
            KIND_NORMAL: eligible = user_mode && top_zero;
            KIND_BTB:    eligible = 1'b0;   // raw virtual address only
            KIND_BKPT:   eligible = 1'b0;   // already modified
            KIND_DESC:   eligible = 1'b0;   // already modified
            default:     eligible = 1'b0;
        endcase
        remapped = eligible;
        if (eligible) begin
            addr_out = {pid, addr_in[LOW_W-1:0]};
        end else begin
            addr_out = addr_in;
        end
    end
endmodule

// File: rtl/pid_remap.sv
module pid_remap
    import pid_remap_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pid_wr_en,
    input  logic [ADDR_W-1:0] pid_wr_data,
    output logic [ADDR_W-1:0] pid_rd_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_remapped,
    output logic              btb_inval
);
    logic [PID_W-1:0] pid_cur;
    acc_kind_e        kind_e;

    assign kind_e = acc_kind_e'(req_kind);

    pid_reg #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pid_wr_en),
        .wr_data (pid_wr_data),
        .pid     (pid_cur),
        .rd_data (pid_rd_data)
    );

    pid_inval_gen u_inval (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pid_wr_en),
        .inval (btb_inval)
    );

    pid_addr_xlate #(.ADDR_W(ADDR_W), .PID_W(PID_W)) u_xlate (
        .addr_in   (req_addr),
        .user_mode (req_user),
        .kind      (kind_e),
        .pid       (pid_cur),
        .addr_out  (out_addr),
        .remapped  (out_remapped)
    );
endmodule

// File: rtl/pid_remap_chk.sv
module pid_remap_chk #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pid_wr_en,
    input logic [ADDR_W-1:0] pid_wr_data,
    input logic [ADDR_W-1:0] pid_rd_data,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_user,
    input logic [1:0]        req_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_remapped,
    input logic              btb_inval
);
    localparam int LOW_W = ADDR_W - PID_W;

    AST_USER_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_user && req_kind == 2'b00 && req_addr[ADDR_W-1 -: PID_W] == '0)
        |-> (out_addr == {pid_rd_data[ADDR_W-1 -: PID_W], req_addr[LOW_W-1:0]})); // R1

    AST_PRIV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_user |-> (out_addr == req_addr)); // R2

    AST_BTB_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_kind == 2'b01) |-> (out_addr == req_addr && !out_remapped)); // R3

    AST_PREMOD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_kind[1] |-> (out_addr == req_addr)); // R4

    AST_PID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        pid_wr_en |=> (pid_rd_data[ADDR_W-1 -: PID_W] == $past(pid_wr_data[ADDR_W-1 -: PID_W]))); // R6

    AST_PID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pid_wr_en |=> $stable(pid_rd_data)); // R6

    AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pid_wr_en |=> btb_inval); // R7

    AST_INVAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pid_wr_en |=> !btb_inval); // R7

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !out_remapped |-> (out_addr == req_addr)); // R9
endmodule

bind pid_remap pid_remap_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pid_wr_en    (pid_wr_en),
    .pid_wr_data  (pid_wr_data),
    .pid_rd_data  (pid_rd_data),
    .req_addr     (req_addr),
    .req_user     (req_user),
    .req_kind     (req_kind),
    .out_addr     (out_addr),
    .out_remapped (out_remapped),
    .btb_inval    (btb_inval)
);

// File: tb/pid_remap_tb.sv
module pid_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pid_wr_en = 1'b0;
    logic [31:0] pid_wr_data = '0;
    logic [31:0] pid_rd_data;
    logic [31:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] out_addr;
    logic        out_remapped;
    logic        btb_inval;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int unsigned m_pid   = 0;
    bit          m_inval = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pid_remap dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pid_wr_en    (pid_wr_en),
        .pid_wr_data  (pid_wr_data),
        .pid_rd_data  (pid_rd_data),
        .req_addr     (req_addr),
        .req_user     (req_user),
        .req_kind     (req_kind),
        .out_addr     (out_addr),
        .out_remapped (out_remapped),
        .btb_inval    (btb_inval)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare all outputs, then advance the model at posedge
    task automatic step(input bit wr, input logic [31:0] wd, input logic [31:0] a,
                        input bit u, input logic [1:0] k);
        bit          elig;
        logic [31:0] e_addr;
        string       tag;
        @(negedge clk);
        pid_wr_en = wr; pid_wr_data = wd; req_addr = a; req_user = u; req_kind = k;
        #1;
        elig = u && (k == 2'b00) && (a / 32'h0200_0000 == 0);
        e_addr = elig ? (a + m_pid * 32'h0200_0000) : a;
        if (elig)              tag = "R1";
        else if (!u)           tag = "R2";
        else if (k == 2'b01)   tag = "R3";
        else if (k != 2'b00)   tag = "R4";
        else                   tag = "R5";
        chk(out_addr === e_addr, tag, out_addr, e_addr);
        chk(out_remapped === elig, "R9", {31'd0, out_remapped}, {31'd0, elig});
        chk(pid_rd_data === m_pid * 32'h0200_0000, "R6", pid_rd_data, m_pid * 32'h0200_0000);
        chk(btb_inval === m_inval, "R7", {31'd0, btb_inval}, {31'd0, m_inval});
        @(posedge clk);
        m_inval = wr;
        if (wr) m_pid = wd / 32'h0200_0000;
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        chk(pid_rd_data === 32'd0, "R8", pid_rd_data, 32'd0);
        chk(btb_inval === 1'b0, "R8", {31'd0, btb_inval}, 32'd0);
        rst_n = 1'b1;
        // R8: zero PID after reset makes eligible remap a no-op
        step(0, 0, 32'h0012_3456, 1, 2'b00);
        // R6/R7: write PID 0x55, lower bits set to be ignored
        step(1, 32'hAA01_FFFF, 32'h0000_0100, 1, 2'b00);
        step(0, 0, 32'h0000_0100, 1, 2'b00);            // R1 uses new PID, R7 pulse
        step(0, 0, 32'h0000_0100, 1, 2'b00);            // R7 pulse gone
        step(0, 0, 32'h01FF_FFFF, 1, 2'b00);            // R1 max low field
        step(0, 0, 32'h0200_0000, 1, 2'b00);            // R5 lowest top bit set
        step(0, 0, 32'h8000_0004, 1, 2'b00);            // R5
        step(0, 0, 32'h0000_0040, 0, 2'b00);            // R2
        step(0, 0, 32'h0000_0040, 1, 2'b01);            // R3 user
        step(0, 0, 32'h0000_0040, 0, 2'b01);            // R3 privileged
        step(0, 0, 32'h0000_0040, 1, 2'b10);            // R4 breakpoint
        step(0, 0, 32'h0000_0040, 1, 2'b11);            // R4 descriptor
        // back-to-back writes: pulse each cycle
        step(1, 32'hFE00_0000, 32'h0000_0008, 1, 2'b00);
        step(1, 32'h0200_0000, 32'h0000_0008, 1, 2'b00);
        step(0, 0, 32'h0000_0008, 1, 2'b00);
        step(0, 0, 32'h0000_0008, 1, 2'b00);
        // write of the same value still invalidates
        step(1, 32'h0200_0000, 32'h0000_0008, 1, 2'b00);
        step(0, 0, 32'h0000_0008, 1, 2'b01);
        // mixed pseudo-random traffic
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom_range(1, 0) == 0) a[31:25] = 7'd0;
            step(($urandom_range(7, 0) == 0), $urandom, a,
                 $urandom_range(1, 0) == 1, 2'($urandom_range(3, 0)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule